// File: doc/BRIEF.md
# Streaming Packet Integrity Monitor

This block sits on the receive side of a packet stream and checks what arrives. The stream comes from a FIFO-style sink. The sink presents a data word with start and end markers and a valid flag, plus a flag that says data is available. The monitor drives the read enable back to the sink, and that read enable is the stream's ready.

The first word of each packet carries the length the sender intended. The monitor counts the words it actually takes in and compares the count with that length when the end marker arrives. It also checks that the payload counts upward one step per word, and it detects packets that are missing their start or end marker. Packets that close with no fault of any kind add to a running good-packet count. Any fault raises a sticky error flag and a one-cycle event pulse.

A build parameter selects priority handling. In that mode the available flag gates only the first word of a packet, and the rest of the packet is read regardless of it. A gap input makes the read enable follow a pseudo-random sequence, which inserts read pauses inside packets.

Top module: `pkt_integrity_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears the good-packet count, the sticky error flag, the error pulse and the open-packet state. The random sequence reloads its seed, 16'hACE1.
- R2: A word transfers only in a cycle where `in_valid` and `in_ready` are both high. Words, markers and lengths offered in any other cycle change no output and no packet state.
- R3: With `gap_en` low and PRIORITY=0, `in_ready` equals `in_avail` in every cycle. With PRIORITY=1, `in_ready` equals `in_avail` while no packet is open and is held high while a packet is open.
- R4: With `gap_en` high, `in_ready` is additionally ANDed with bit 0 of a 16-bit shift register. The register loads 16'hACE1 on reset and otherwise shifts left by one bit every cycle. The bit entering at bit 0 is the XOR of bits 15, 13, 12 and 10, which gives the polynomial x^16+x^14+x^13+x^11+1.
- R5: The start word's bits [LEN_W-1:0] give the declared length. The word count includes both the start word and the end word. An end word whose count differs from the declared length is an error.
- R6: From the third word of a packet onward, each word must equal the previous word plus one, modulo 2^DATA_W. A word that breaks this is an error. The second word is not checked.
- R7: A start word that arrives while a packet is open is an error, because the end marker is missing. That word then opens a new packet, and the new packet is judged on its own.
- R8: A word without a start marker, including an end word, that arrives with no packet open is an error, because the start marker is missing. The word is otherwise discarded.
- R9: `pkt_count` rises by one in the cycle after the end word of a packet that had no R5 or R6 error since its start word.
- R10: `error_pulse` is high for exactly the one cycle after each transfer that raised any error. `error_detect` goes high with the first pulse and stays high until reset.
- R11: A single word that carries both markers forms a complete packet. It passes when its declared length is 1 and is a length error otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_en | input | 1 | Enables pseudo-random read gaps |
| in_data | input | DATA_W | Stream data word |
| in_sop | input | 1 | Start-of-packet marker |
| in_eop | input | 1 | End-of-packet marker |
| in_valid | input | 1 | Word on the stream is valid |
| in_avail | input | 1 | Sink reports data available |
| in_ready | output | 1 | Read enable to the sink (stream ready) |
| pkt_count | output | CNT_W | Running count of good packets |
| error_detect | output | 1 | Sticky error flag |
| error_pulse | output | 1 | One-cycle pulse per error event |

## Verification
`in_ready` is combinational from `in_avail`, `gap_en`, the open-packet state and the shift register. The bench therefore checks it in the same cycle, a short settle time after it drives its inputs on the falling edge. `pkt_count`, `error_pulse` and `error_detect` are registered once behind the transfer edge. The bench drives each word on a falling edge and reads those outputs on the next falling edge, after exactly one rising edge. In gap mode the bench keeps its own copy of the shift register, stepped on every rising edge from the stated seed, and compares `in_ready` against bit 0 of that copy every cycle.

// File: rtl/pim_pkg.sv
package pim_pkg;

  typedef struct packed {
    logic len_err;
    logic pat_err;
    logic no_eop;
    logic no_sop;
  } pim_err_t;

  localparam logic [15:0] PIM_LFSR_SEED = 16'hACE1;

  function automatic logic [15:0] pim_lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/pim_gap_lfsr.sv
module pim_gap_lfsr
  import pim_pkg::*;
#(
  parameter logic [15:0] SEED = PIM_LFSR_SEED
) (
  input  logic clk,
  input  logic rst,
  output logic gap_bit
);
  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= pim_lfsr_step(state_q);
  end

  assign gap_bit = state_q[0];

  // R4: a nonzero seed must never decay to the all-zero lock-up state
  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    state_q != 16'h0000);
endmodule

// File: rtl/pim_read_gate.sv
module pim_read_gate #(
  parameter int PRIORITY = 0
) (
  input  logic gap_en,
  input  logic gap_bit,
  input  logic avail,
  input  logic pkt_open,
  output logic ready
);
  logic pace_ok;
  logic skip_avail;

  assign pace_ok    = !gap_en || gap_bit;
  assign skip_avail = (PRIORITY != 0) && pkt_open;
  assign ready      = pace_ok && (avail || skip_avail);
endmodule

// File: rtl/pim_frame_tracker.sv
module pim_frame_tracker
  import pim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer,
  input  logic              sop,
  input  logic              eop,
  input  logic [DATA_W-1:0] data,
  output logic              pkt_open,
  output pim_err_t          err,
  output logic              done_good
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  logic              open_q, open_n;
  logic              bad_q, bad_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n, cnt_inc;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [DATA_W-1:0] prev_q, prev_n;
  logic [LEN_W-1:0]  decl_len;

  assign decl_len = data[LEN_W-1:0];
  assign cnt_inc  = (cnt_q == '1) ? cnt_q : cnt_q + ONE;

  always_comb begin
    err       = '0;
    done_good = 1'b0;
    open_n    = open_q;
    bad_n     = bad_q;
    cnt_n     = cnt_q;
    len_n     = len_q;
    prev_n    = prev_q;
    if (xfer) begin
      if (sop) begin
        err.no_eop = open_q;
        len_n      = decl_len;
        prev_n     = data;
        cnt_n      = ONE;
        bad_n      = 1'b0;
        if (eop) begin
          err.len_err = (decl_len != ONE);
          done_good   = (decl_len == ONE);
          open_n      = 1'b0;
        end else begin
          open_n = 1'b1;
        end
      end else if (!open_q) begin
        err.no_sop = 1'b1;
      end else begin
        err.pat_err = (cnt_q >= TWO) && (data != prev_q + DATA_W'(1));
        prev_n      = data;
        cnt_n       = cnt_inc;
        if (eop) begin
          err.len_err = (cnt_inc != len_q);
          done_good   = !bad_q && !err.pat_err && (cnt_inc == len_q);
          open_n      = 1'b0;
        end else begin
          bad_n = bad_q || err.pat_err;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      bad_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      prev_q <= '0;
    end else begin
      open_q <= open_n;
      bad_q  <= bad_n;
      cnt_q  <= cnt_n;
      len_q  <= len_n;
      prev_q <= prev_n;
    end
  end

  assign pkt_open = open_q;

  // R2: packet state moves only on a transfer
  assert_idle_holds_state_R2: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> ($stable(open_q) && $stable(cnt_q) && $stable(len_q)));

  // R5: an end word without a start marker always closes the open packet
  assert_eop_closes_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer && eop && !sop && open_q) |=> !open_q);

  // R7: a start word always leaves a packet open unless it also ends it
  assert_sop_opens_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer && sop && !eop) |=> (open_q && cnt_q == ONE));
endmodule

// File: rtl/pim_err_status.sv
module pim_err_status
  import pim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pim_err_t         err,
  input  logic             done_good,
  output logic [CNT_W-1:0] pkt_count,
  output logic             error_detect,
  output logic             error_pulse
);
  logic any_err;
  assign any_err = |err;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_count    <= '0;
      error_detect <= 1'b0;
      error_pulse  <= 1'b0;
    end else begin
      error_pulse  <= any_err;
      error_detect <= error_detect || any_err;
      if (done_good) pkt_count <= pkt_count + CNT_W'(1);
    end
  end

  // R10: the flag never falls without reset
  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    error_detect |=> error_detect);

  // R10: every event pulse is reflected in the sticky flag
  assert_pulse_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
    error_pulse |-> error_detect);

  // R9: the good-packet count advances by at most one per cycle
  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    ##1 (pkt_count == $past(pkt_count) || pkt_count == $past(pkt_count) + CNT_W'(1)));
endmodule

// File: rtl/pkt_integrity_monitor.sv
module pkt_integrity_monitor
  import pim_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          LEN_W    = 16,
  parameter int          CNT_W    = 16,
  parameter int          PRIORITY = 0,
  parameter logic [15:0] SEED     = PIM_LFSR_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gap_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_valid,
  input  logic              in_avail,
  output logic              in_ready,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              error_detect,
  output logic              error_pulse
);
  logic     gap_bit;
  logic     pkt_open;
  logic     xfer;
  logic     done_good;
  pim_err_t err;

  assign xfer = in_valid && in_ready;

  pim_gap_lfsr #(.SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .gap_bit (gap_bit)
  );

  pim_read_gate #(.PRIORITY(PRIORITY)) u_gate (
    .gap_en   (gap_en),
    .gap_bit  (gap_bit),
    .avail    (in_avail),
    .pkt_open (pkt_open),
    .ready    (in_ready)
  );

  pim_frame_tracker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .sop       (in_sop),
    .eop       (in_eop),
    .data      (in_data),
    .pkt_open  (pkt_open),
    .err       (err),
    .done_good (done_good)
  );

  pim_err_status #(.CNT_W(CNT_W)) u_status (
    .clk          (clk),
    .rst          (rst),
    .err          (err),
    .done_good    (done_good),
    .pkt_count    (pkt_count),
    .error_detect (error_detect),
    .error_pulse  (error_pulse)
  );

  // R3: without gaps an available sink is always read
  assert_no_gap_reads_R3: assert property (@(posedge clk) disable iff (rst)
    (!gap_en && in_avail) |-> in_ready);

  // R3: in data mode the sink is never read while it reports nothing available
  assert_obey_avail_R3: assert property (@(posedge clk) disable iff (rst)
    (PRIORITY == 0 && in_ready) |-> in_avail);

  // R1: after reset nothing is flagged
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!error_detect && !error_pulse && pkt_count == '0));
endmodule

// File: tb/pkt_integrity_monitor_bench.sv
module pkt_integrity_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gap_en = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0, in_avail = 1'b1;
  logic        rdy_d, err_d, pul_d, rdy_p, err_p, pul_p;
  logic [15:0] cnt_d, cnt_p;
  logic [15:0] model_lfsr;
  int          n_tests = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  pkt_integrity_monitor #(.PRIORITY(0)) u_pkt_integrity_monitor (
    .clk(clk), .rst(rst), .gap_en(gap_en), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_valid(in_valid), .in_avail(in_avail), .in_ready(rdy_d),
    .pkt_count(cnt_d), .error_detect(err_d), .error_pulse(pul_d));

  pkt_integrity_monitor #(.PRIORITY(1)) u_pkt_integrity_monitor_pri (
    .clk(clk), .rst(rst), .gap_en(gap_en), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_valid(in_valid), .in_avail(in_avail), .in_ready(rdy_p),
    .pkt_count(cnt_p), .error_detect(err_p), .error_pulse(pul_p));

  // R4 model from the stated seed and taps
  always @(posedge clk) begin
    if (rst) model_lfsr <= 16'hACE1;
    else     model_lfsr <= {model_lfsr[14:0],
                            model_lfsr[15] ^ model_lfsr[13] ^ model_lfsr[12] ^ model_lfsr[10]};
  end

  typedef struct packed {
    logic        sop;
    logic        eop;
    logic [31:0] data;
    logic        pulse;
    logic [7:0]  cnt;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 32'd3,  1'b0, 8'd0},  // R5 open, length 3
    '{1'b0, 1'b0, 32'd10, 1'b0, 8'd0},
    '{1'b0, 1'b1, 32'd11, 1'b0, 8'd1},  // R9 good close
    '{1'b1, 1'b1, 32'd1,  1'b0, 8'd2},  // R11 single word
    '{1'b1, 1'b0, 32'd2,  1'b0, 8'd2},
    '{1'b0, 1'b1, 32'd50, 1'b0, 8'd3},  // R6 second word unchecked
    '{1'b1, 1'b0, 32'd4,  1'b0, 8'd3},
    '{1'b0, 1'b0, 32'd7,  1'b0, 8'd3},
    '{1'b0, 1'b0, 32'd9,  1'b1, 8'd3},  // R6 break
    '{1'b0, 1'b1, 32'd10, 1'b0, 8'd3},  // R9 tainted packet not counted
    '{1'b0, 1'b0, 32'd5,  1'b1, 8'd3},  // R8 data with nothing open
    '{1'b0, 1'b1, 32'd6,  1'b1, 8'd3},  // R8 end with nothing open
    '{1'b1, 1'b0, 32'd3,  1'b0, 8'd3},
    '{1'b0, 1'b0, 32'd4,  1'b0, 8'd3},
    '{1'b1, 1'b0, 32'd2,  1'b1, 8'd3},  // R7 start while open
    '{1'b0, 1'b1, 32'd20, 1'b0, 8'd4},  // R7 new packet judged alone
    '{1'b1, 1'b0, 32'd5,  1'b0, 8'd4},
    '{1'b0, 1'b1, 32'd1,  1'b1, 8'd4},  // R5 short packet
    '{1'b1, 1'b0, 32'd2,  1'b0, 8'd4},
    '{1'b0, 1'b1, 32'd99, 1'b0, 8'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic e,
                       input logic [31:0] d, input logic av);
    in_valid = v; in_sop = s; in_eop = e; in_data = d; in_avail = av;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; gap_en = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 32'd0, 1'b1);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic sticky;
    do_reset();
    // R1 reset state
    check("R1 count", {16'd0, cnt_d}, 32'd0);
    check("R1 flag", {31'd0, err_d}, 32'd0);
    check("R1 pulse", {31'd0, pul_d}, 32'd0);

    // table walk: every word transfers, result due one edge later
    sticky = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].sop, VEC[i].eop, VEC[i].data, 1'b1);
      @(negedge clk);
      sticky = sticky | VEC[i].pulse;
      check($sformatf("R5-R11 vec%0d pulse", i), {31'd0, pul_d}, {31'd0, VEC[i].pulse});
      check($sformatf("R9 vec%0d count", i), {16'd0, cnt_d}, {24'd0, VEC[i].cnt});
      check($sformatf("R10 vec%0d flag", i), {31'd0, err_d}, {31'd0, sticky});
    end
    // R10 sticky while idle
    drive(1'b0, 1'b0, 1'b0, 32'd0, 1'b1);
    repeat (5) @(negedge clk);
    check("R10 flag held", {31'd0, err_d}, 32'd1);
    check("R10 pulse ends", {31'd0, pul_d}, 32'd0);

    // R1 reset clears errors
    do_reset();
    check("R1 flag cleared", {31'd0, err_d}, 32'd0);
    check("R1 count cleared", {16'd0, cnt_d}, 32'd0);

    // R2 offered words without valid are ignored
    drive(1'b1, 1'b1, 1'b0, 32'd2, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 32'd7, 1'b1);
    @(negedge clk);
    check("R2 no pulse", {31'd0, pul_d}, 32'd0);
    check("R2 no count", {16'd0, cnt_d}, 32'd0);
    // R3 data mode: not available means not ready, nothing taken
    drive(1'b1, 1'b0, 1'b1, 32'd55, 1'b0);
    #1;
    check("R3 ready follows avail", {31'd0, rdy_d}, 32'd0);
    check("R3 priority ready in packet", {31'd0, rdy_p}, 32'd1);
    @(negedge clk);
    check("R2 blocked word ignored", {16'd0, cnt_d}, 32'd0);
    check("R3 priority took word", {16'd0, cnt_p}, 32'd1);
    drive(1'b1, 1'b0, 1'b1, 32'd55, 1'b1);
    @(negedge clk);
    check("R9 count after close", {16'd0, cnt_d}, 32'd1);
    drive(1'b0, 1'b0, 1'b0, 32'd0, 1'b0);
    #1;
    check("R3 priority idle obeys avail", {31'd0, rdy_p}, 32'd0);

    // R4 gap mode against model
    do_reset();
    gap_en = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 32'd0, 1'b1);
    for (int k = 0; k < 40; k++) begin
      #1;
      check($sformatf("R4 gap cycle %0d", k), {31'd0, rdy_d}, {31'd0, model_lfsr[0]});
      @(negedge clk);
    end
    gap_en = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule